// File: doc/BRIEF.md
# Switch Interrupt Roll-up Register Pair

This block gathers the interrupt summaries of five switch sub-systems into one pending word: three port MACs, the switch engine and the buffer manager. Each sub-system presents a single level input that means "something unmasked is pending inside me". The block samples every input on each clock and latches it into a sticky bit of a 32-bit read-only pending word. A read of the word clears those bits. A companion mask word selects which pending bits may raise one registered summary interrupt. That interrupt feeds the next interrupt level up.

Software reaches the two words through a small register port. The port accepts one request per cycle and answers a read one cycle later with a valid strobe. The pending bits occupy fixed, non-contiguous positions, and the unused positions between them read as zero.

Top module: `irq_rollup`

## Requirements
- R1: The pending word is 32 bits. Bit 0 holds src_req[0] (port 0 MAC), bit 1 holds src_req[1] (port 1 MAC), bit 2 holds src_req[2] (port 2 MAC), bit 5 holds src_req[3] (switch engine) and bit 6 holds src_req[4] (buffer manager). Every other bit of both words reads as zero.
- R2: A source input that is high at a rising clock edge sets its pending bit. A read issued in the next cycle returns the bit as 1.
- R3: A pending bit stays set after its source drops, until a read of the pending word.
- R4: A read of the pending word (bus_addr 0) returns the value held before the read. After that edge every bit is 0, except the bits whose sources are high in the read cycle; those stay set.
- R5: After reset the pending word is 0, the mask word is 0x0000_0067, sum_irq is 0 and bus_rvalid is 0.
- R6: The mask word (bus_addr 1) can be read and written. A 1 in a bit masks that source. Written values for positions outside R1's five bits are dropped.
- R7: sum_irq is a register equal to the OR of (pending AND NOT mask) as those words stand after each edge. It drops in the cycle after a clearing read, unless a source is high in the read cycle. It follows a mask write in the cycle after the write.
- R8: A write to bus_addr 0 leaves the pending word unchanged.
- R9: A read request (bus_req=1, bus_we=0) produces bus_rvalid=1 with bus_rdata in the following cycle. A read of any other address returns 0. A write produces no bus_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 pending, 1 mask |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| src_req | input | 5 | Per-source "unmasked event pending" levels |
| sum_irq | output | 1 | Registered summary interrupt |

## Verification
A wrong pending bit shows up at sum_irq in the cycle right after the edge that corrupts it, as long as that bit is unmasked. It also shows up in bus_rdata on the next read. A wrong mask bit shows up the same way, in the cycle after the mask write. A clear that comes too early or too late shows up as a wrong sum_irq level in the cycle after the read, and as a lost event on the following read. Moving the sources through every bit position with the mask open and then closed finds a mapping fault within one read.

// File: rtl/irq_rollup_pkg.sv
package irq_rollup_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_SRC = 5;
  localparam int ADDR_W  = 2;
  localparam logic [ADDR_W-1:0] PEND_ADDR = 2'd0;
  localparam logic [ADDR_W-1:0] MASK_ADDR = 2'd1;

  // bit position of each source inside the pending word
  localparam int SRC_POS [NUM_SRC] = '{0, 1, 2, 5, 6};

  function automatic logic [DATA_W-1:0] place_src(input logic [NUM_SRC-1:0] req);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int k = 0; k < NUM_SRC; k++) v[SRC_POS[k]] = req[k];
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] live_bits();
    return place_src({NUM_SRC{1'b1}});
  endfunction

  function automatic logic any_open(input logic [DATA_W-1:0] pend,
                                    input logic [DATA_W-1:0] mask);
    return |(pend & ~mask);
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] pend_d
);
  // sticky bits: a clear loses to a set arriving in the same cycle
  always_comb pend_d = ((clr ? '0 : pend_q) | set_vec) & LIVE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] mask_d
);
  always_comb mask_d = wr_en ? (wdata & LIVE) : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= LIVE;
    else        mask_q <= mask_d;
  end
endmodule

// File: rtl/irq_rd_port.sv
module irq_rd_port #(
  parameter int W = 32,
  parameter int AW = 2,
  parameter logic [AW-1:0] A_PEND = '0,
  parameter logic [AW-1:0] A_MASK = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_ev,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  pend_q,
  input  logic [W-1:0]  mask_q,
  output logic [W-1:0]  rdata,
  output logic          rvalid
);
  logic [W-1:0] sel_data;

  always_comb begin
    unique case (addr)
      A_PEND:  sel_data = pend_q;
      A_MASK:  sel_data = mask_q;
      default: sel_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_ev;
      if (rd_ev) rdata <= sel_data;
    end
  end
endmodule

// File: rtl/irq_rollup.sv
module irq_rollup
  import irq_rollup_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [NUM_SRC-1:0] src_req,
  output logic              sum_irq
);
  localparam logic [DATA_W-1:0] LIVE = live_bits();

  // named internal events, visible to the bound checker
  logic              rd_ev, rd_pend_ev, wr_mask_ev;
  logic [DATA_W-1:0] src_bits;
  logic [DATA_W-1:0] pend_q, pend_d, mask_q, mask_d;

  assign rd_ev      = bus_req & ~bus_we;
  assign rd_pend_ev = rd_ev & (bus_addr == PEND_ADDR);
  assign wr_mask_ev = bus_req & bus_we & (bus_addr == MASK_ADDR);
  assign src_bits   = place_src(src_req);

  irq_pend_bank #(.W(DATA_W), .LIVE(LIVE)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_vec(src_bits), .clr(rd_pend_ev),
    .pend_q(pend_q), .pend_d(pend_d));

  irq_mask_reg #(.W(DATA_W), .LIVE(LIVE)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_mask_ev), .wdata(bus_wdata),
    .mask_q(mask_q), .mask_d(mask_d));

  irq_rd_port #(.W(DATA_W), .AW(ADDR_W), .A_PEND(PEND_ADDR), .A_MASK(MASK_ADDR)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_ev(rd_ev), .addr(bus_addr),
    .pend_q(pend_q), .mask_q(mask_q), .rdata(bus_rdata), .rvalid(bus_rvalid));

  // summary taken from next-state words so it tracks the registers exactly
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_irq <= 1'b0;
    else        sum_irq <= any_open(pend_d, mask_d);
  end
endmodule

// File: rtl/irq_rollup_chk.sv
module irq_rollup_chk
  import irq_rollup_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] pend,
  input logic [DATA_W-1:0] mask,
  input logic [DATA_W-1:0] src_bits,
  input logic              rd_pend,
  input logic              rd_any,
  input logic              sum_irq,
  input logic              rvalid,
  input logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] LIVE = live_bits();

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> ((rdata & ~LIVE) == '0));

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(src_bits)) == $past(src_bits)));

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_pend |=> ((pend & $past(pend)) == $past(pend)));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |=> ((pend & ~$past(src_bits)) == '0));

  p_mask_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask & ~LIVE) == '0);

  p_summary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sum_irq == |(pend & ~mask));

  p_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> rvalid);

  p_no_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> !rvalid);
endmodule

bind irq_rollup irq_rollup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pend(pend_q), .mask(mask_q),
  .src_bits(src_bits), .rd_pend(rd_pend_ev), .rd_any(rd_ev),
  .sum_irq(sum_irq), .rvalid(bus_rvalid), .rdata(bus_rdata));

// File: tb/tb_irq_rollup.sv
module tb_irq_rollup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [4:0]  src_req = '0;
  logic        sum_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_rollup dut (.clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .src_req(src_req), .sum_irq(sum_irq));

  typedef struct packed {
    logic [31:0] mask; logic [4:0] src; logic [31:0] pend; logic irq;
  } vec_t;
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h0,        5'b00001, 32'h01, 1'b1},
    '{32'h0,        5'b00010, 32'h02, 1'b1},
    '{32'h0,        5'b00100, 32'h04, 1'b1},
    '{32'h0,        5'b01000, 32'h20, 1'b1},
    '{32'h0,        5'b10000, 32'h40, 1'b1},
    '{32'h67,       5'b11111, 32'h67, 1'b0},
    '{32'h20,       5'b01000, 32'h20, 1'b0},
    '{32'h20,       5'b01001, 32'h21, 1'b1},
    '{32'hFFFFFF98, 5'b10100, 32'h44, 1'b1}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    tick();
    chk("R9 write no rvalid", {31'b0, bus_rvalid}, 32'h0);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    bus_req = 1; bus_we = 0; bus_addr = a;
    tick();
    chk("R9 rvalid", {31'b0, bus_rvalid}, 32'h1);
    d = bus_rdata;
    bus_req = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    #5; rst_n = 1; #2;
    // reset state
    chk("R5 sum_irq", {31'b0, sum_irq}, 32'h0);
    chk("R5 rvalid", {31'b0, bus_rvalid}, 32'h0);
    bus_read(2'd0, d); chk("R5 pending", d, 32'h0);
    bus_read(2'd1, d); chk("R5 mask", d, 32'h67);

    // vector table: R1, R2, R6, R7
    for (int i = 0; i < NV; i++) begin
      bus_write(2'd1, VECS[i].mask);
      src_req = VECS[i].src; tick(); src_req = '0;
      chk("R7 sum_irq after event", {31'b0, sum_irq}, {31'b0, VECS[i].irq});
      bus_read(2'd0, d);
      chk("R1 R2 pending layout", d, VECS[i].pend);
      chk("R7 sum_irq drops after clearing read", {31'b0, sum_irq}, 32'h0);
    end

    // R6: reserved mask bits dropped
    bus_write(2'd1, 32'hFFFFFFFF);
    bus_read(2'd1, d); chk("R6 mask readback", d, 32'h67);

    // R7: unmask existing pending bit
    src_req = 5'b00010; tick(); src_req = '0;
    chk("R7 masked no irq", {31'b0, sum_irq}, 32'h0);
    bus_write(2'd1, 32'h0);
    chk("R7 irq after unmask", {31'b0, sum_irq}, 32'h1);
    bus_read(2'd0, d); chk("R7 pending", d, 32'h02);

    // R3: sticky
    src_req = 5'b00001; tick(); src_req = '0;
    repeat (5) tick();
    chk("R3 irq held", {31'b0, sum_irq}, 32'h1);
    bus_read(2'd0, d); chk("R3 sticky pending", d, 32'h01);

    // R4: event during the read cycle survives
    src_req = 5'b10000; tick();
    src_req = 5'b01000;
    bus_read(2'd0, d); src_req = '0;
    chk("R4 read old value", d, 32'h40);
    chk("R4 irq kept", {31'b0, sum_irq}, 32'h1);
    bus_read(2'd0, d); chk("R4 same-cycle event kept", d, 32'h20);
    chk("R4 irq cleared", {31'b0, sum_irq}, 32'h0);

    // R8: writes to pending ignored
    src_req = 5'b00001; tick(); src_req = '0;
    bus_write(2'd0, 32'h0);
    bus_write(2'd0, 32'hFFFFFFFF);
    chk("R8 irq unchanged", {31'b0, sum_irq}, 32'h1);
    bus_read(2'd0, d); chk("R8 pending unchanged", d, 32'h01);

    // R9: unmapped address
    bus_read(2'd2, d); chk("R9 unmapped reads zero", d, 32'h0);
    bus_read(2'd3, d); chk("R9 unmapped reads zero", d, 32'h0);
    tick();
    chk("R9 rvalid idle", {31'b0, bus_rvalid}, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule